// File: doc/BRIEF.md
# Debug Configuration Register Access Chain

This block is a 39-bit data register that sits behind a JTAG TAP controller. It lets a debugger read and write a bank of 32-bit processor configuration registers. The TAP supplies one-cycle capture, shift and update strobes on the test clock, together with TDI. The block drives TDO from the low end of its chain. Each scan word holds three fields: a direction flag at the top, a 6-bit register address below it, and a 32-bit data field at the bottom.

A write takes one scan. The debugger shifts in the flag set to 1, the address and the data, and the addressed register takes the data at Update-DR. A read takes two passes. The first scan, with the flag at 0, names the address; Update-DR stores the flag and address in a held command register. The next Capture-DR loads the chain with the held flag, the held address and the value of that register. A second scan then shifts the result out.

Each address carries its own access type, which the decoder enforces. There are read-only identification values, read/write configuration registers, an indexed group of region registers, and write-only operations. A write-only operation raises a one-cycle flush strobe and stores nothing.

Top module: `cfg_scan_port`

## Requirements
- R1: The chain is 1 + 6 + DATA_W bits long (39 by default). In a cycle where the shift strobe is high and the capture strobe is low, TDI enters the top bit, every bit moves one place toward bit 0, and TDO always shows bit 0. A word shifted in LSB first comes out LSB first after a full-length scan.
- R2: In a cycle where the update strobe is high, the direction flag (top bit) and the address (the 6 bits above the data field) are copied from the chain into the held command register.
- R3: In a cycle where the capture strobe is high, the chain loads {held flag, held address, read value}. The read value comes from the register named by the held address.
- R4: An update with the flag at 1 and a read/write address stores the data field in that register. The read/write addresses are control 0x02, process identifier 0x1B and cache index 0x3A. An update with the flag at 0 changes no register.
- R5: Address {1, n[3:0], 0} (0x20 + 2n) selects region register n, for n below NUM_REGIONS. Region registers are read/write and independent of each other.
- R6: Addresses 0x00 (identification) and 0x01 (cache type) are read-only. A capture returns the matching stub input, and a write to either address changes nothing.
- R7: Addresses 0x0E (data flush) and 0x0F (instruction flush) are write-only. A write raises the matching flush output for exactly the one cycle after the update edge, and stores nothing. A capture from either address returns zero data.
- R8: Any address not listed in R4 to R7 is unmapped. A capture returns zero data, and a write changes no register and raises no flush output.
- R9: After reset, all stored registers and the chain are zero, the held command is read of address 0x00, and both flush outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture-DR strobe |
| shift_en | input | 1 | Shift-DR strobe |
| upd_en | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| id_value | input | DATA_W | Stub value of the identification register |
| ctype_value | input | DATA_W | Stub value of the cache type register |
| ctrl_q | output | DATA_W | Control register contents |
| pid_q | output | DATA_W | Process identifier register contents |
| cidx_q | output | DATA_W | Cache index register contents |
| region_q | output | NUM_REGIONS*DATA_W | Region registers, region n at bits [n*DATA_W +: DATA_W] |
| flush_d_pulse | output | 1 | One-cycle data flush strobe |
| flush_i_pulse | output | 1 | One-cycle instruction flush strobe |

## Verification
The bench builds the block with its defaults: DATA_W of 32 and NUM_REGIONS of 8. These defaults give the full 39-bit chain and all eight region slots, so region 7 at 0x2E is the last mapped entry and region index 8 (0x30) is the first unmapped one. Every readback uses the real two-pass sequence, so one read also confirms the held flag and address fields in the captured header. The region boundary, the read-only and write-only addresses, and unmapped codes such as 0x30 and 0x3F are all driven through the serial port.

// File: rtl/cfg_scan_pkg.sv
package cfg_scan_pkg;

  localparam int ADDR_W = 6;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_WO   = 2'd2,
    ACC_RW   = 2'd3
  } acc_e;

  // Fixed register codes, written as {hi, mid[3:0], lo}
  localparam logic [ADDR_W-1:0] A_ID      = 6'b0_0000_0;
  localparam logic [ADDR_W-1:0] A_CTYPE   = 6'b0_0000_1;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'b0_0001_0;
  localparam logic [ADDR_W-1:0] A_FLUSH_D = 6'b0_0111_0;
  localparam logic [ADDR_W-1:0] A_FLUSH_I = 6'b0_0111_1;
  localparam logic [ADDR_W-1:0] A_PID     = 6'b0_1101_1;
  localparam logic [ADDR_W-1:0] A_CIDX    = 6'b1_1101_0;

  typedef struct packed {
    logic id;
    logic ctype;
    logic ctrl;
    logic pid;
    logic cidx;
    logic flush_d;
    logic flush_i;
  } fix_sel_t;

endpackage

// File: rtl/scan_shifter.sv
module scan_shifter #(
  parameter int CHAIN_W = 39
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               shift_en,
  input  logic               tdi,
  input  logic [CHAIN_W-1:0] cap_word,
  output logic [CHAIN_W-1:0] chain_q,
  output logic               tdo
);

  logic [CHAIN_W-1:0] chain_d;
  logic               chain_en;

  // capture has priority over shift if both are ever raised together
  always_comb begin
    chain_d  = chain_q;
    chain_en = cap_en | shift_en;
    if (cap_en) begin
      chain_d = cap_word;
    end else if (shift_en) begin
      chain_d = {tdi, chain_q[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (chain_en) begin
      chain_q <= chain_d;
    end
  end

  assign tdo = chain_q[0];

endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_scan_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic [ADDR_W-1:0]      addr,
  output fix_sel_t               sel,
  output logic [NUM_REGIONS-1:0] region_sel,
  output acc_e                   acc
);

  localparam logic [4:0] REGION_LIM = 5'(NUM_REGIONS);

  logic [3:0] region_idx;
  logic       region_hit;

  assign region_idx = addr[4:1];
  assign region_hit = addr[ADDR_W-1] & ~addr[0] & ({1'b0, region_idx} < REGION_LIM);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rsel
    assign region_sel[g] = region_hit && (region_idx == 4'(g));
  end

  always_comb begin
    sel = '0;
    acc = ACC_NONE;
    case (addr)
      A_ID:      begin sel.id      = 1'b1; acc = ACC_RO; end
      A_CTYPE:   begin sel.ctype   = 1'b1; acc = ACC_RO; end
      A_CTRL:    begin sel.ctrl    = 1'b1; acc = ACC_RW; end
      A_PID:     begin sel.pid     = 1'b1; acc = ACC_RW; end
      A_CIDX:    begin sel.cidx    = 1'b1; acc = ACC_RW; end
      A_FLUSH_D: begin sel.flush_d = 1'b1; acc = ACC_WO; end
      A_FLUSH_I: begin sel.flush_i = 1'b1; acc = ACC_WO; end
      default:   acc = region_hit ? ACC_RW : ACC_NONE;
    endcase
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_scan_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_stb,
  input  fix_sel_t                      wr_sel,
  input  logic [NUM_REGIONS-1:0]        wr_region_sel,
  input  acc_e                          wr_acc,
  input  logic [DATA_W-1:0]             wr_data,
  input  fix_sel_t                      rd_sel,
  input  logic [NUM_REGIONS-1:0]        rd_region_sel,
  input  acc_e                          rd_acc,
  input  logic [DATA_W-1:0]             id_value,
  input  logic [DATA_W-1:0]             ctype_value,
  output logic [DATA_W-1:0]             ctrl_q,
  output logic [DATA_W-1:0]             pid_q,
  output logic [DATA_W-1:0]             cidx_q,
  output logic [NUM_REGIONS*DATA_W-1:0] region_q,
  output logic                          flush_d_pulse,
  output logic                          flush_i_pulse,
  output logic [DATA_W-1:0]             rd_data
);

  logic wr_rw, wr_wo, rd_ok;
  logic we_ctrl, we_pid, we_cidx;
  logic flush_d_d, flush_i_d;
  logic [DATA_W-1:0] region_r [NUM_REGIONS];
  logic [DATA_W-1:0] rd_mux;

  // Read-only codes have no storage and flush codes have no readback.
  logic unused_sel_bits;
  assign unused_sel_bits = wr_sel.id | wr_sel.ctype | rd_sel.flush_d | rd_sel.flush_i;

  assign wr_rw = wr_stb && (wr_acc == ACC_RW);
  assign wr_wo = wr_stb && (wr_acc == ACC_WO);
  assign rd_ok = (rd_acc == ACC_RO) || (rd_acc == ACC_RW);

  assign we_ctrl   = wr_rw & wr_sel.ctrl;
  assign we_pid    = wr_rw & wr_sel.pid;
  assign we_cidx   = wr_rw & wr_sel.cidx;
  assign flush_d_d = wr_wo & wr_sel.flush_d;
  assign flush_i_d = wr_wo & wr_sel.flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (we_ctrl) ctrl_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pid_q <= '0;
    else if (we_pid) pid_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cidx_q <= '0;
    else if (we_cidx) cidx_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_d_pulse <= 1'b0;
      flush_i_pulse <= 1'b0;
    end else begin
      flush_d_pulse <= flush_d_d;
      flush_i_pulse <= flush_i_d;
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic we_region;
    assign we_region = wr_rw & wr_region_sel[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) region_r[g] <= '0;
      else if (we_region) region_r[g] <= wr_data;
    end
    assign region_q[g*DATA_W +: DATA_W] = region_r[g];
  end

  always_comb begin
    rd_mux = '0;
    if (rd_sel.id)    rd_mux = rd_mux | id_value;
    if (rd_sel.ctype) rd_mux = rd_mux | ctype_value;
    if (rd_sel.ctrl)  rd_mux = rd_mux | ctrl_q;
    if (rd_sel.pid)   rd_mux = rd_mux | pid_q;
    if (rd_sel.cidx)  rd_mux = rd_mux | cidx_q;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (rd_region_sel[i]) rd_mux = rd_mux | region_r[i];
    end
  end

  assign rd_data = rd_ok ? rd_mux : '0;

endmodule

// File: rtl/cfg_scan_port.sv
module cfg_scan_port
  import cfg_scan_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic                          shift_en,
  input  logic                          upd_en,
  input  logic                          tdi,
  output logic                          tdo,
  input  logic [DATA_W-1:0]             id_value,
  input  logic [DATA_W-1:0]             ctype_value,
  output logic [DATA_W-1:0]             ctrl_q,
  output logic [DATA_W-1:0]             pid_q,
  output logic [DATA_W-1:0]             cidx_q,
  output logic [NUM_REGIONS*DATA_W-1:0] region_q,
  output logic                          flush_d_pulse,
  output logic                          flush_i_pulse
);

  localparam int CMD_W   = 1 + ADDR_W;
  localparam int CHAIN_W = CMD_W + DATA_W;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] cap_word;
  logic [CMD_W-1:0]   held_q, held_d;
  logic [DATA_W-1:0]  rd_data;

  fix_sel_t               wr_sel, rd_sel;
  logic [NUM_REGIONS-1:0] wr_region_sel, rd_region_sel;
  acc_e                   wr_acc, rd_acc;
  logic                   wr_stb;

  scan_shifter #(.CHAIN_W(CHAIN_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .tdi      (tdi),
    .cap_word (cap_word),
    .chain_q  (chain_q),
    .tdo      (tdo)
  );

  // held command: {flag, address}
  always_comb begin
    held_d = held_q;
    if (upd_en) held_d = chain_q[CHAIN_W-1:DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (upd_en) held_q <= held_d;
  end

  cfg_addr_decode #(.NUM_REGIONS(NUM_REGIONS)) u_wr_dec (
    .addr       (chain_q[DATA_W +: ADDR_W]),
    .sel        (wr_sel),
    .region_sel (wr_region_sel),
    .acc        (wr_acc)
  );

  cfg_addr_decode #(.NUM_REGIONS(NUM_REGIONS)) u_rd_dec (
    .addr       (held_q[ADDR_W-1:0]),
    .sel        (rd_sel),
    .region_sel (rd_region_sel),
    .acc        (rd_acc)
  );

  assign wr_stb   = upd_en & chain_q[CHAIN_W-1];
  assign cap_word = {held_q, rd_data};

  cfg_reg_bank #(.DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .wr_sel        (wr_sel),
    .wr_region_sel (wr_region_sel),
    .wr_acc        (wr_acc),
    .wr_data       (chain_q[DATA_W-1:0]),
    .rd_sel        (rd_sel),
    .rd_region_sel (rd_region_sel),
    .rd_acc        (rd_acc),
    .id_value      (id_value),
    .ctype_value   (ctype_value),
    .ctrl_q        (ctrl_q),
    .pid_q         (pid_q),
    .cidx_q        (cidx_q),
    .region_q      (region_q),
    .flush_d_pulse (flush_d_pulse),
    .flush_i_pulse (flush_i_pulse),
    .rd_data       (rd_data)
  );

endmodule

// File: rtl/cfg_scan_port_chk.sv
module cfg_scan_port_chk
  import cfg_scan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cap_en,
  input logic                           shift_en,
  input logic                           upd_en,
  input logic                           tdi,
  input logic [ADDR_W+DATA_W:0]         chain_q,
  input logic [ADDR_W:0]                held_q,
  input logic [DATA_W-1:0]              ctrl_q,
  input logic                           flush_d_pulse,
  input logic                           flush_i_pulse
);

  localparam int CHAIN_W = ADDR_W + DATA_W + 1;

  // R1
  shift_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (chain_q == {$past(tdi), $past(chain_q[CHAIN_W-1:1])}));

  // R2
  held_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (held_q == $past(chain_q[CHAIN_W-1:DATA_W])));

  // R3
  cap_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (chain_q[CHAIN_W-1:DATA_W] == $past(held_q)));

  // R4
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && chain_q[CHAIN_W-1] && chain_q[DATA_W +: ADDR_W] == A_CTRL)
      |=> (ctrl_q == $past(chain_q[DATA_W-1:0])));

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(ctrl_q));

  // R7
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_d_pulse |-> $past(upd_en && chain_q[CHAIN_W-1] && chain_q[DATA_W +: ADDR_W] == A_FLUSH_D));

  // R7
  flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_d_pulse, flush_i_pulse}));

  // R7
  flush_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && (held_q[ADDR_W-1:0] == A_FLUSH_D || held_q[ADDR_W-1:0] == A_FLUSH_I))
      |=> (chain_q[DATA_W-1:0] == '0));

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && held_q[ADDR_W-1:0] == 6'b1_1111_1) |=> (chain_q[DATA_W-1:0] == '0));

endmodule

bind cfg_scan_port cfg_scan_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cap_en        (cap_en),
  .shift_en      (shift_en),
  .upd_en        (upd_en),
  .tdi           (tdi),
  .chain_q       (chain_q),
  .held_q        (held_q),
  .ctrl_q        (ctrl_q),
  .flush_d_pulse (flush_d_pulse),
  .flush_i_pulse (flush_i_pulse)
);

// File: tb/cfg_scan_port_bench.sv
module cfg_scan_port_bench;

  localparam int TCK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NR = 8;
  localparam int AW = 6;
  localparam int CW = 1 + AW + DW;

  localparam logic [DW-1:0] ID_VAL    = 32'h4107_9260;
  localparam logic [DW-1:0] CTYPE_VAL = 32'h0D17_2172;

  logic clk, rst_n, cap_en, shift_en, upd_en, tdi, tdo;
  logic [DW-1:0] id_value, ctype_value, ctrl_q, pid_q, cidx_q;
  logic [NR*DW-1:0] region_q;
  logic flush_d_pulse, flush_i_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [CW-1:0] exp_q [$];
  string         tag_q [$];
  logic [CW-1:0] obs_q [$];

  cfg_scan_port #(.DATA_W(DW), .NUM_REGIONS(NR)) u_cfg_scan_port (
    .clk (clk), .rst_n (rst_n), .cap_en (cap_en), .shift_en (shift_en),
    .upd_en (upd_en), .tdi (tdi), .tdo (tdo),
    .id_value (id_value), .ctype_value (ctype_value),
    .ctrl_q (ctrl_q), .pid_q (pid_q), .cidx_q (cidx_q), .region_q (region_q),
    .flush_d_pulse (flush_d_pulse), .flush_i_pulse (flush_i_pulse)
  );

  initial clk = 1'b0;
  always #(TCK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops observed scan-out words against the scoreboard
  always @(negedge clk) begin
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic [CW-1:0] o, e;
      string t;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(o === e, t, o, e);
    end
  end

  task automatic shift_word(input logic [CW-1:0] win, output logic [CW-1:0] wout);
    shift_en = 1'b1;
    for (int i = 0; i < CW; i++) begin
      tdi = win[i];
      @(negedge clk);
      wout[i] = tdo;
      @(posedge clk); #1;
    end
    shift_en = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic do_update(output logic pd, output logic pi, output logic pd2, output logic pi2);
    upd_en = 1'b1;
    @(posedge clk); #1;
    upd_en = 1'b0;
    @(negedge clk);
    pd = flush_d_pulse; pi = flush_i_pulse;
    @(posedge clk); #1;
    @(negedge clk);
    pd2 = flush_d_pulse; pi2 = flush_i_pulse;
    @(posedge clk); #1;
  endtask

  task automatic do_capture();
    cap_en = 1'b1;
    @(posedge clk); #1;
    cap_en = 1'b0;
  endtask

  task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output logic [3:0] pulses);
    logic [CW-1:0] junk;
    logic pd, pi, pd2, pi2;
    shift_word({1'b1, a, d}, junk);
    do_update(pd, pi, pd2, pi2);
    pulses = {pd, pi, pd2, pi2};
  endtask

  // driver: pushes the expected header+data, then runs the two-pass read
  task automatic read_reg(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    logic [CW-1:0] junk, got;
    logic pd, pi, pd2, pi2;
    exp_q.push_back({1'b0, a, exp});
    tag_q.push_back(req);
    shift_word({1'b0, a, 32'h0}, junk);
    do_update(pd, pi, pd2, pi2);
    do_capture();
    shift_word('0, got);
    obs_q.push_back(got);
    @(negedge clk);
  endtask

  initial begin
    #(TCK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] p;
    logic [CW-1:0] a_out, b_out, junk;
    logic [DW-1:0] rexp [NR];
    logic [NR*DW-1:0] reg_snap;
    logic [DW-1:0] c_snap, p_snap, x_snap;

    rst_n = 1'b0; cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0; tdi = 1'b0;
    id_value = ID_VAL; ctype_value = CTYPE_VAL;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state at the ports
    check(ctrl_q == '0 && pid_q == '0 && cidx_q == '0, "R9 regs", CW'(ctrl_q), '0);
    check(region_q == '0, "R9 regions", CW'(region_q[DW-1:0]), '0);
    check(!flush_d_pulse && !flush_i_pulse, "R9 flush", CW'({flush_d_pulse, flush_i_pulse}), '0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9 held command is read of 0x00: capture right away returns the id
    exp_q.push_back({1'b0, 6'h00, ID_VAL}); tag_q.push_back("R9 held default");
    do_capture();
    shift_word('0, a_out);
    obs_q.push_back(a_out);
    @(negedge clk);

    // R1 serial pass-through: a word shifted in comes back out on the next scan
    shift_word(39'h5A_DEAD_BEEF, junk);
    shift_word(39'h00_0000_0000, b_out);
    check(b_out == 39'h5A_DEAD_BEEF, "R1 passthrough", b_out, 39'h5A_DEAD_BEEF);
    shift_word(39'h7F_FFFF_FFFF, junk);
    shift_word(39'h00_0000_0000, b_out);
    check(b_out == 39'h7F_FFFF_FFFF, "R1 all ones", b_out, 39'h7F_FFFF_FFFF);

    // R6 read-only values
    read_reg(6'h00, ID_VAL, "R6 id read");
    read_reg(6'h01, CTYPE_VAL, "R6 ctype read");

    // R4 read/write registers, R2 held address visible in header
    write_reg(6'h02, 32'h1234_5678, p);
    check(ctrl_q == 32'h1234_5678, "R4 ctrl port", CW'(ctrl_q), CW'(32'h1234_5678));
    check(p == 4'b0000, "R7 no flush on ctrl", CW'(p), '0);
    write_reg(6'h1B, 32'hCAFE_0001, p);
    check(pid_q == 32'hCAFE_0001, "R4 pid port", CW'(pid_q), CW'(32'hCAFE_0001));
    write_reg(6'h3A, 32'h0000_0FC0, p);
    check(cidx_q == 32'h0000_0FC0, "R4 cidx port", CW'(cidx_q), CW'(32'h0000_0FC0));
    read_reg(6'h02, 32'h1234_5678, "R4 ctrl read");
    read_reg(6'h1B, 32'hCAFE_0001, "R4 pid read");
    read_reg(6'h3A, 32'h0000_0FC0, "R4 cidx read");
    check(ctrl_q == 32'h1234_5678, "R4 read scan leaves ctrl", CW'(ctrl_q), CW'(32'h1234_5678));

    // R5 regions 0..NR-1
    for (int n = 0; n < NR; n++) begin
      rexp[n] = 32'hA500_0000 | DW'(n * 32'h0001_0203);
      write_reg({1'b1, 4'(n), 1'b0}, rexp[n], p);
    end
    for (int n = 0; n < NR; n++) begin
      check(region_q[n*DW +: DW] == rexp[n], "R5 region port",
            CW'(region_q[n*DW +: DW]), CW'(rexp[n]));
      read_reg({1'b1, 4'(n), 1'b0}, rexp[n], "R5 region read");
    end

    // R6 writes to read-only codes ignored
    c_snap = ctrl_q; p_snap = pid_q; x_snap = cidx_q; reg_snap = region_q;
    write_reg(6'h00, 32'hFFFF_FFFF, p);
    write_reg(6'h01, 32'h0BAD_0BAD, p);
    read_reg(6'h00, ID_VAL, "R6 id after write");
    read_reg(6'h01, CTYPE_VAL, "R6 ctype after write");
    check(ctrl_q == c_snap && pid_q == p_snap && cidx_q == x_snap && region_q == reg_snap,
          "R6 no side effect", CW'(ctrl_q), CW'(c_snap));

    // R7 flush strobes
    write_reg(6'h0E, 32'h1111_1111, p);
    check(p == 4'b1000, "R7 data flush pulse", CW'(p), CW'(4'b1000));
    write_reg(6'h0F, 32'h2222_2222, p);
    check(p == 4'b0100, "R7 instr flush pulse", CW'(p), CW'(4'b0100));
    read_reg(6'h0E, 32'h0, "R7 data flush read");
    read_reg(6'h0F, 32'h0, "R7 instr flush read");
    check(ctrl_q == c_snap && pid_q == p_snap && cidx_q == x_snap && region_q == reg_snap,
          "R7 nothing stored", CW'(ctrl_q), CW'(c_snap));

    // R8 unmapped codes: first region past the limit, all ones, odd region code
    write_reg(6'h30, 32'hDEAD_DEAD, p);
    check(p == 4'b0000, "R8 no flush", CW'(p), '0);
    write_reg(6'h3F, 32'hDEAD_DEAD, p);
    write_reg(6'h21, 32'hDEAD_DEAD, p);
    check(ctrl_q == c_snap && pid_q == p_snap && cidx_q == x_snap && region_q == reg_snap,
          "R8 write ignored", CW'(region_q[DW-1:0]), CW'(reg_snap[DW-1:0]));
    read_reg(6'h30, 32'h0, "R8 read 0x30");
    read_reg(6'h3F, 32'h0, "R8 read 0x3F");
    read_reg(6'h21, 32'h0, "R8 read 0x21");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && obs_q.size() == 0, "R3 scoreboard drained",
          CW'(exp_q.size()), '0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule